// File: doc/BRIEF.md
# Interrupt Aggregator with Pin-Change Detection

This block gathers every interrupt cause of a small microcontroller core into one request line for the CPU and one wake-up line for the power controller. There are three core causes: a timer rollover pulse, a rising edge on an external interrupt pin, and a change on a six-pin port. A parameterised group of peripheral flags is also collected. Each peripheral flag is ANDed with its own enable. The peripheral results are ORed together, and that OR passes through a peripheral gate. The gated peripheral term is then ORed with the enabled core terms, and a global gate turns the result into the CPU request. The wake-up line is taken from the same OR before the global gate, so a sleeping core can be woken with interrupts globally masked.

Port-change detection keeps a snapshot of the synchronised pin levels. Any read of the port reloads this snapshot. When an enabled pin differs from the snapshot, the change flag is set. A mismatch in the same clock cycle as a port read is taken into the snapshot and never raises the flag. Software clears a sticky flag by writing the register that holds it. If hardware sets the flag in the same cycle, the hardware set wins.

Top module: `irq_agg`

## Requirements
- R1: After reset every register reads 0x00, and `irq` and `wake` are low.
- R2: A one-cycle `tmr_wrap` pulse sets control bit 2 on the same clock edge. Control bit 5 is that flag's enable.
- R3: The external pin passes through a two-flop synchroniser. A rising edge sets control bit 1 on the third clock edge after the pin changes. A falling edge sets nothing. Control bit 4 is that flag's enable.
- R4: Change-enable register (address 1, bits 5:0, one bit per pin). A synchronised pin whose enable bit is 1 and whose level differs from the snapshot sets control bit 0. Pins whose enable bit is 0 never set it. Control bit 3 is that flag's enable.
- R5: A read at address 4 with `rd_en` high reloads the snapshot with the synchronised pins. A mismatch in that same cycle does not set control bit 0.
- R6: Peripheral flags live at address 2 and peripheral enables at address 3. Bit n of the flag register is set by a pulse on `per_set[n]`. The OR of the flag-AND-enable terms counts only while control bit 6 is 1.
- R7: `irq` is high exactly when control bit 7 is 1 and either a core flag with its enable is set or the gated peripheral term is high.
- R8: `wake` is high exactly when a core flag with its enable is set or the gated peripheral term is high. Control bit 7 has no effect on it.
- R9: Flags are sticky. A write to address 0 or 2 loads the written value into the flag bits. A hardware set in the same cycle takes priority over a written 0.
- R10: `rd_data` is combinational from `addr`: 0 control, 1 change enables, 2 peripheral flags, 3 peripheral enables, 4 synchronised pin levels. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_wrap | input | 1 | Timer rollover pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pin | input | NPIN | Asynchronous port pins watched for change |
| per_set | input | NPER | Peripheral flag set pulses |
| addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, used to detect port reads |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-up request, not gated by the global enable |

## Verification
Directed patterns drive one source at a time and then move the gates around it. This separates a missing peripheral gate from a missing global gate, and separates the wake-up path from the request path. Pin stimulus covers a disabled pin, an enabled pin, a change that lands in a port-read cycle and a falling external edge, which tells real change and edge detection apart from level sensing. Seeded random writes to the control and peripheral registers, mixed with random set pulses, compare `irq`, `wake` and read-back against a bench model. This catches wrong bit positions, wrong gate order and wrong set-over-clear priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int DW = 8;
   localparam int AW = 3;
   localparam int NCORE = 3;
   // control register bit positions
   localparam int CTL_CHG_F = 0;
   localparam int CTL_EXT_F = 1;
   localparam int CTL_TMR_F = 2;
   localparam int CTL_CHG_E = 3;
   localparam int CTL_EXT_E = 4;
   localparam int CTL_TMR_E = 5;
   localparam int CTL_PER_G = 6;
   localparam int CTL_GLB_G = 7;
   typedef enum logic [AW-1:0] {
      SEL_CTL    = 3'd0,
      SEL_CHG_EN = 3'd1,
      SEL_PER_F  = 3'd2,
      SEL_PER_E  = 3'd3,
      SEL_PORT   = 3'd4
   } sel_e;
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqa_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("irqa_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irqa_flags.sv
module irqa_flags #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("irqa_flags width must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= hw_set | (wr ? wdata : q);
   end

   // R9
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irqa_chg.sv
module irqa_chg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] en,
   input  logic         rd,
   output logic         hit
);
   logic [W-1:0] snap;
   logic [W-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  snap <= '0;
      else if (rd) snap <= pins;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         assign diff[i] = (pins[i] ^ snap[i]) & en[i];
      end
   endgenerate

   assign hit = (|diff) & ~rd;
endmodule

// File: rtl/irqa_tree.sv
module irqa_tree
   import irq_agg_pkg::*;
#(
   parameter int NPER = 8
) (
   input  logic [DW-1:0]   ctl,
   input  logic [NPER-1:0] per_f,
   input  logic [NPER-1:0] per_e,
   output logic            irq,
   output logic            wake
);
   logic [NPER-1:0] per_hit;
   logic            per_any;
   logic            core_any;
   logic            pre_glb;

   generate
      for (genvar i = 0; i < NPER; i++) begin : g_src
         assign per_hit[i] = per_f[i] & per_e[i];
      end
   endgenerate

   assign per_any  = (|per_hit) & ctl[CTL_PER_G];
   assign core_any = (ctl[CTL_TMR_F] & ctl[CTL_TMR_E])
                   | (ctl[CTL_EXT_F] & ctl[CTL_EXT_E])
                   | (ctl[CTL_CHG_F] & ctl[CTL_CHG_E]);
   assign pre_glb  = core_any | per_any;
   assign wake     = pre_glb;
   assign irq      = pre_glb & ctl[CTL_GLB_G];
endmodule

// File: rtl/irq_agg.sv
module irq_agg
   import irq_agg_pkg::*;
#(
   parameter int NPIN        = 6,
   parameter int NPER        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tmr_wrap,
   input  logic            ext_pin,
   input  logic [NPIN-1:0] port_pin,
   input  logic [NPER-1:0] per_set,
   input  logic [AW-1:0]   addr,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   input  logic            rd_en,
   output logic [DW-1:0]   rd_data,
   output logic            irq,
   output logic            wake
);
   localparam int SW  = NPIN + 1;
   localparam int NEN = DW - NCORE;

   generate
      if (NPIN < 1 || NPIN > DW) begin : g_bad_npin
         $error("NPIN must be 1..8");
      end
      if (NPER < 1 || NPER > DW) begin : g_bad_nper
         $error("NPER must be 1..8");
      end
   endgenerate

   logic [SW-1:0]    sy;
   logic [NPIN-1:0]  pins_s;
   logic             ext_s;
   logic             ext_d;
   logic             ext_rise;
   logic             chg_hit;
   logic             port_rd;
   logic             wr_ctl;
   logic             wr_pf;
   logic [NCORE-1:0] core_f;
   logic [NEN-1:0]   core_e;
   logic [NPIN-1:0]  chg_en;
   logic [NPER-1:0]  per_f;
   logic [NPER-1:0]  per_e;
   logic [DW-1:0]    ctl;

   irqa_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ext_pin, port_pin}), .q(sy));

   assign pins_s = sy[NPIN-1:0];
   assign ext_s  = sy[NPIN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_d <= 1'b0;
      else        ext_d <= ext_s;
   end
   assign ext_rise = ext_s & ~ext_d;

   assign port_rd = rd_en  && (addr == SEL_PORT);
   assign wr_ctl  = wr_en  && (addr == SEL_CTL);
   assign wr_pf   = wr_en  && (addr == SEL_PER_F);

   irqa_chg #(.W(NPIN)) u_chg (
      .clk(clk), .rst_n(rst_n), .pins(pins_s), .en(chg_en),
      .rd(port_rd), .hit(chg_hit));

   irqa_flags #(.W(NCORE)) u_core_f (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctl), .wdata(wr_data[NCORE-1:0]),
      .hw_set({tmr_wrap, ext_rise, chg_hit}), .q(core_f));

   irqa_flags #(.W(NPER)) u_per_f (
      .clk(clk), .rst_n(rst_n), .wr(wr_pf), .wdata(wr_data[NPER-1:0]),
      .hw_set(per_set), .q(per_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_e <= '0;
         chg_en <= '0;
         per_e  <= '0;
      end else if (wr_en) begin
         case (addr)
            SEL_CTL:    core_e <= wr_data[DW-1:NCORE];
            SEL_CHG_EN: chg_en <= wr_data[NPIN-1:0];
            SEL_PER_E:  per_e  <= wr_data[NPER-1:0];
            default: ;
         endcase
      end
   end

   assign ctl = {core_e, core_f};

   always_comb begin
      rd_data = '0;
      case (addr)
         SEL_CTL:    rd_data = ctl;
         SEL_CHG_EN: rd_data[NPIN-1:0] = chg_en;
         SEL_PER_F:  rd_data[NPER-1:0] = per_f;
         SEL_PER_E:  rd_data[NPER-1:0] = per_e;
         SEL_PORT:   rd_data[NPIN-1:0] = pins_s;
         default:    rd_data = '0;
      endcase
   end

   irqa_tree #(.NPER(NPER)) u_tree (
      .ctl(ctl), .per_f(per_f), .per_e(per_e), .irq(irq), .wake(wake));

   // R5
   port_read_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && !ctl[CTL_CHG_F]) |=> !ctl[CTL_CHG_F]);
   // R7
   irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl[CTL_GLB_G]);
   // R8
   irq_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> wake);
   // R2
   tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wrap |=> ctl[CTL_TMR_F]);
endmodule

// File: tb/irq_agg_test.sv
module irq_agg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_wrap = 1'b0;
   logic       ext_pin = 1'b0;
   logic [5:0] port_pin = '0;
   logic [7:0] per_set = '0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq;
   logic       wake;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   irq_agg uut (
      .clk(clk), .rst_n(rst_n), .tmr_wrap(tmr_wrap), .ext_pin(ext_pin),
      .port_pin(port_pin), .per_set(per_set), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
      .wake(wake));

   function automatic logic f_wake(input logic [7:0] c, input logic [7:0] pf,
                                   input logic [7:0] pe);
      logic core;
      core = (c[2] & c[5]) | (c[1] & c[4]) | (c[0] & c[3]);
      return core | (c[6] & (|(pf & pe)));
   endfunction

   function automatic logic f_irq(input logic [7:0] c, input logic [7:0] pf,
                                  input logic [7:0] pe);
      return c[7] & f_wake(c, pf, pe);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [2:0] a,
                       input logic [7:0] exp);
      addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] m_ctl, m_pf, m_pe;
      void'($urandom(32'd1234));
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      for (int a = 0; a < 5; a++) rchk("R1 reset reg", a[2:0], 8'h00);
      chk("R1 irq", irq, 0);
      chk("R1 wake", wake, 0);

      // R2 timer wrap
      @(negedge clk); tmr_wrap = 1'b1;
      @(negedge clk); tmr_wrap = 1'b0;
      rchk("R2 timer flag", 3'd0, 8'h04);
      chk("R2 no wake when disabled", wake, 0);
      wr(3'd0, 8'h24);
      chk("R8 wake without global", wake, 1);
      chk("R7 irq blocked by global", irq, 0);
      wr(3'd0, 8'hA4);
      chk("R7 irq with global", irq, 1);
      wr(3'd0, 8'h80);
      rchk("R9 software clear", 3'd0, 8'h80);
      chk("R9 irq after clear", irq, 0);

      // R9 hardware set beats software clear
      @(negedge clk);
      addr = 3'd0; wr_data = 8'h00; wr_en = 1'b1; tmr_wrap = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tmr_wrap = 1'b0;
      rchk("R9 set over clear", 3'd0, 8'h04);
      wr(3'd0, 8'h00);

      // R3 external rising edge, three edges of latency
      @(negedge clk); ext_pin = 1'b1;
      idle(2);
      rchk("R3 not yet set", 3'd0, 8'h00);
      idle(1);
      rchk("R3 rising edge sets", 3'd0, 8'h02);
      wr(3'd0, 8'h00);
      @(negedge clk); ext_pin = 1'b0;
      idle(5);
      rchk("R3 falling edge ignored", 3'd0, 8'h00);

      // R4 disabled pin is ignored
      @(negedge clk); port_pin = 6'h04;
      idle(5);
      rchk("R4 disabled pin", 3'd0, 8'h00);
      wr(3'd1, 8'hFC);
      rchk("R10 enable readback", 3'd1, 8'h3C);
      wr(3'd1, 8'h04);
      idle(2);
      rchk("R4 enabled mismatch sets", 3'd0, 8'h01);
      rchk("R10 port level", 3'd4, 8'h04);
      @(negedge clk); addr = 3'd4; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      wr(3'd0, 8'h00);
      idle(3);
      rchk("R5 read reloads snapshot", 3'd0, 8'h00);

      // R5 change in the read cycle is lost
      wr(3'd1, 8'h0C);
      @(negedge clk); port_pin = 6'h0C;
      @(negedge clk);
      @(negedge clk); addr = 3'd4; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      idle(3);
      rchk("R5 lost change", 3'd0, 8'h00);
      @(negedge clk); port_pin = 6'h1C;
      idle(4);
      rchk("R4 pin 4 disabled", 3'd0, 8'h00);
      rchk("R10 unused address", 3'd6, 8'h00);

      // R6 peripheral gating
      wr(3'd3, 8'h21);
      @(negedge clk); per_set = 8'h20;
      @(negedge clk); per_set = 8'h00;
      rchk("R6 peripheral flag", 3'd2, 8'h20);
      wr(3'd0, 8'h80);
      chk("R6 gate closed irq", irq, 0);
      chk("R6 gate closed wake", wake, 0);
      wr(3'd0, 8'hC0);
      chk("R6 gate open irq", irq, 1);
      chk("R8 gate open wake", wake, 1);
      wr(3'd3, 8'h01);
      chk("R6 source disabled", irq, 0);
      wr(3'd0, 8'h40);
      wr(3'd3, 8'h20);
      chk("R8 wake needs no global", wake, 1);
      chk("R7 no global no irq", irq, 0);

      // random phase, R7 R8 R9 R6 against the model
      m_ctl = 8'h40; m_pf = 8'h20; m_pe = 8'h20;
      for (int it = 0; it < 300; it++) begin
         logic [2:0] wa, ra;
         logic [7:0] wd, ps;
         logic       we, tw;
         @(negedge clk);
         case ($urandom % 3) 0: wa = 3'd0; 1: wa = 3'd2; default: wa = 3'd3; endcase
         wd = 8'($urandom);
         wd[3] = 1'b0; wd[0] = 1'b0;
         we = ($urandom % 3) == 0;
         ps = 8'($urandom) & 8'($urandom) & 8'($urandom);
         tw = ($urandom % 8) == 0;
         addr = wa; wr_data = wd; wr_en = we; per_set = ps; tmr_wrap = tw;
         if (we && wa == 3'd0) m_ctl = {wd[7:3], wd[2:0]};
         if (we && wa == 3'd3) m_pe = wd;
         m_pf = ps | ((we && wa == 3'd2) ? wd : m_pf);
         if (tw) m_ctl[2] = 1'b1;
         @(negedge clk);
         wr_en = 1'b0; per_set = '0; tmr_wrap = 1'b0;
         case ($urandom % 3) 0: ra = 3'd0; 1: ra = 3'd2; default: ra = 3'd3; endcase
         chk("R7 random irq", irq, f_irq(m_ctl, m_pf, m_pe));
         chk("R8 random wake", wake, f_wake(m_ctl, m_pf, m_pe));
         rchk("R9 random readback", ra,
              (ra == 3'd0) ? m_ctl : (ra == 3'd2) ? m_pf : m_pe);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule